// File: doc/BRIEF.md
# Four-by-Four Inverse Transform Reconstructor

This block rebuilds one 4x4 tile of 8-bit pixels from sixteen signed residual coefficients and sixteen prediction pixels. The coefficients go through a separable integer inverse transform. A vertical 1-D pass runs over each column. A horizontal 1-D pass then runs over each row of that intermediate result. The transpose between the two passes is done by indexing, so no data is moved.

Every 1-D pass is a four-point butterfly. It uses two fixed-point rotation factors in Q16 (20091 and 35468), and all of its sums saturate to signed 16 bits. After the second pass each value is rounded down by a factor of eight. The result is added to its prediction pixel and clamped to an unsigned byte.

A caller presents a whole tile on parallel buses and pulses `start_i` while `ready_o` is high. The reconstructed tile appears on `pix_o` together with a one-cycle `done_o` pulse. Upstream logic handles dequantization, entropy decoding and frame addressing.

Top module: `idct4_recon`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `ready_o` is 1, `done_o` is 0 and `pix_o` is all zero.
- R2: A `start_i` sampled high while `ready_o` is high is accepted. `ready_o` is low for the next cycle only. `done_o` is high for exactly one cycle, two clock edges after the accepting edge.
- R3: A `start_i` sampled while `ready_o` is low has no effect: it neither produces a further `done_o` pulse nor changes the result.
- R4: Element k of the tile (raster order, k = 4*row + col) is taken from `coef_i[13k+12:13k]` as a two's-complement value in -4096..4095. Its prediction comes from `pred_i[8k+7:8k]` as an unsigned byte, and its result goes to `pix_o[8k+7:8k]`.
- R5: A 1-D pass on inputs x0..x3 forms a = x0+x2 and b = x0-x2. It also forms c = S(x1)-C(x3) and d = C(x1)+S(x3). Here S(x) = x + ((x*(-30068))>>16) and C(x) = x + ((x*20091)>>16), with arithmetic shifts. Its outputs, in order, are a+d, b+c, b-c and a-d.
- R6: The first pass runs on each column, with x0..x3 at rows 0..3. The second pass runs on each row of the first pass's result, with x0..x3 at columns 0..3. Each pass's outputs go back to the positions their inputs came from.
- R7: Every addition and subtraction in both passes, including those inside S and C, saturates to -32768..32767.
- R8: Each second-pass value v becomes (v+4)>>3 with an arithmetic shift, computed without overflow.
- R9: Each rounded residual is added to its prediction pixel, and the sum is clamped to 0..255.
- R10: `pix_o` changes only on the edge that raises `done_o`, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to process the tile on the input buses |
| ready_o | output | 1 | Block is idle and will accept `start_i` |
| coef_i | input | 208 | Sixteen 13-bit signed coefficients, raster order, element 0 in the low bits |
| pred_i | input | 128 | Sixteen 8-bit prediction pixels, raster order |
| done_o | output | 1 | One-cycle pulse marking a new result on `pix_o` |
| pix_o | output | 128 | Sixteen 8-bit reconstructed pixels, raster order |

## Verification
The assertions assume the caller's `start_i` is synchronous and meaningful only when `ready_o` is high. They also assume that a start arriving while busy is dropped and not queued. The stimulus holds `start_i` high for several consecutive cycles with changing data to exercise the dropped-start case. It also drives every coefficient through a two's-complement 13-bit field, so no value outside -4096..4095 ever reaches the transform. The extremes of that range (all 4095, all -4096) are driven on purpose to push the second pass into saturation. Prediction bytes of 0 and 255 are used to reach both clamp limits.

// File: rtl/idct4_pkg.sv
package idct4_pkg;

    localparam int NPT    = 4;
    localparam int NEL    = NPT * NPT;
    localparam int ACC_W  = 16;
    localparam int FRAC   = 16;
    localparam int RND_SH = 3;
    localparam int PIX_MX = 255;

    typedef logic signed [ACC_W-1:0] acc_t;
    typedef logic signed [ACC_W:0]   wide_t;
    typedef acc_t [NEL-1:0]          blk_t;

    localparam acc_t K_COS = acc_t'(20091);
    localparam acc_t K_SIN = acc_t'(35468 - 65536);

    typedef enum logic {ST_IDLE, ST_BUSY} state_e;

    function automatic acc_t clip(wide_t s);
        if (s[ACC_W] != s[ACC_W-1])
            return s[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
        return s[ACC_W-1:0];
    endfunction

    function automatic acc_t qadd(acc_t a, acc_t b);
        wide_t s;
        s = {a[ACC_W-1], a} + {b[ACC_W-1], b};
        return clip(s);
    endfunction

    function automatic acc_t qsub(acc_t a, acc_t b);
        wide_t s;
        s = {a[ACC_W-1], a} - {b[ACC_W-1], b};
        return clip(s);
    endfunction

    function automatic acc_t mulhi(acc_t a, acc_t k);
        logic signed [ACC_W+FRAC-1:0] p;
        p = (ACC_W+FRAC)'(a) * (ACC_W+FRAC)'(k);
        return p[ACC_W+FRAC-1:FRAC];
    endfunction

    function automatic acc_t scale_c(acc_t x);
        return qadd(x, mulhi(x, K_COS));
    endfunction

    function automatic acc_t scale_s(acc_t x);
        return qadd(x, mulhi(x, K_SIN));
    endfunction

endpackage

// File: rtl/idct4_bfly.sv
module idct4_bfly
    import idct4_pkg::*;
(
    input  acc_t x0,
    input  acc_t x1,
    input  acc_t x2,
    input  acc_t x3,
    output acc_t y0,
    output acc_t y1,
    output acc_t y2,
    output acc_t y3
);
    acc_t ev_sum, ev_dif, od_c, od_d;

    always_comb begin
        ev_sum = qadd(x0, x2);
        ev_dif = qsub(x0, x2);
        od_c   = qsub(scale_s(x1), scale_c(x3));
        od_d   = qadd(scale_c(x1), scale_s(x3));
        y0     = qadd(ev_sum, od_d);
        y1     = qadd(ev_dif, od_c);
        y2     = qsub(ev_dif, od_c);
        y3     = qsub(ev_sum, od_d);
    end
endmodule

// File: rtl/idct4_pass.sv
module idct4_pass
    import idct4_pkg::*;
#(
    parameter bit COLS = 1'b1
) (
    input  blk_t din,
    output blk_t dout
);
    localparam int STEP = COLS ? NPT : 1;

    for (genvar g = 0; g < NPT; g++) begin : g_lane
        localparam int BASE = COLS ? g : g * NPT;
        idct4_bfly u_bfly (
            .x0 (din[BASE]),
            .x1 (din[BASE + STEP]),
            .x2 (din[BASE + 2*STEP]),
            .x3 (din[BASE + 3*STEP]),
            .y0 (dout[BASE]),
            .y1 (dout[BASE + STEP]),
            .y2 (dout[BASE + 2*STEP]),
            .y3 (dout[BASE + 3*STEP])
        );
    end
endmodule

// File: rtl/idct4_px.sv
module idct4_px
    import idct4_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  acc_t             v,
    input  logic [PIX_W-1:0] pred,
    output logic [PIX_W-1:0] pix
);
    wide_t ext, rnd, sum;

    always_comb begin
        ext = {v[ACC_W-1], v};
        rnd = (ext + wide_t'(4)) >>> RND_SH;
        sum = rnd + $signed(wide_t'(pred));
        if (sum < 0)
            pix = '0;
        else if (sum > wide_t'(PIX_MX))
            pix = PIX_W'(PIX_MX);
        else
            pix = sum[PIX_W-1:0];
    end
endmodule

// File: rtl/idct4_recon.sv
module idct4_recon
    import idct4_pkg::*;
#(
    parameter int COEF_W = 13,
    parameter int PIX_W  = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    output logic                   ready_o,
    input  logic [NEL*COEF_W-1:0]  coef_i,
    input  logic [NEL*PIX_W-1:0]   pred_i,
    output logic                   done_o,
    output logic [NEL*PIX_W-1:0]   pix_o
);
    state_e                 state_q;
    blk_t                   in_blk, col_res, row_res, mid_q;
    logic [NEL*PIX_W-1:0]   pred_q, pix_d, pix_q;
    logic                   done_q;

    for (genvar k = 0; k < NEL; k++) begin : g_unpack
        assign in_blk[k] = acc_t'($signed(coef_i[k*COEF_W +: COEF_W]));
    end

    idct4_pass #(.COLS(1'b1)) u_col (.din(in_blk), .dout(col_res));
    idct4_pass #(.COLS(1'b0)) u_row (.din(mid_q),  .dout(row_res));

    for (genvar k = 0; k < NEL; k++) begin : g_px
        idct4_px #(.PIX_W(PIX_W)) u_px (
            .v    (row_res[k]),
            .pred (pred_q[k*PIX_W +: PIX_W]),
            .pix  (pix_d[k*PIX_W +: PIX_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mid_q   <= '0;
            pred_q  <= '0;
            pix_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state_q == ST_BUSY) begin
                state_q <= ST_IDLE;
                pix_q   <= pix_d;
                done_q  <= 1'b1;
            end else if (start_i) begin
                state_q <= ST_BUSY;
                mid_q   <= col_res;
                pred_q  <= pred_i;
            end
        end
    end

    assign ready_o = (state_q == ST_IDLE);
    assign done_o  = done_q;
    assign pix_o   = pix_q;
endmodule

// File: rtl/idct4_recon_chk.sv
module idct4_recon_chk #(
    parameter int PW = 128
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic          ready_o,
    input logic          done_o,
    input logic [PW-1:0] pix_o
);
    a_r2_done_two_after: assert property (@(posedge clk) disable iff (rst)
        (start_i && ready_o) |-> ##2 done_o);

    a_r2_busy_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (start_i && ready_o) |=> !ready_o ##1 ready_o);

    a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r3_no_done_from_idle: assert property (@(posedge clk) disable iff (rst)
        (ready_o && !start_i) |=> ##1 !done_o);

    a_r10_pix_hold: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(pix_o));
endmodule

bind idct4_recon idct4_recon_chk #(.PW(idct4_pkg::NEL * PIX_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .ready_o (ready_o),
    .done_o  (done_o),
    .pix_o   (pix_o)
);

// File: tb/idct4_recon_tb.sv
module idct4_recon_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 13;
    localparam int PW = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start_i = 1'b0;
    logic [16*CW-1:0] coef_i = '0;
    logic [16*PW-1:0] pred_i = '0;
    logic           ready_o, done_o;
    logic [16*PW-1:0] pix_o;

    int    n_chk = 0, n_fail = 0, cyc = 0;
    string tag = "R1";

    idct4_recon u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .ready_o(ready_o),
        .coef_i(coef_i), .pred_i(pred_i), .done_o(done_o), .pix_o(pix_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference ----------------
    function automatic int s16(int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction
    function automatic int sS(int x); return s16(x + ((x * -30068) >>> 16)); endfunction
    function automatic int sC(int x); return s16(x + ((x * 20091) >>> 16)); endfunction

    function automatic logic [16*PW-1:0] ref_tile(logic [16*CW-1:0] cf, logic [16*PW-1:0] pr);
        int m[16];
        int t[16];
        logic [16*PW-1:0] res;
        for (int k = 0; k < 16; k++) m[k] = int'($signed(cf[k*CW +: CW]));
        for (int p = 0; p < 2; p++) begin
            for (int g = 0; g < 4; g++) begin
                int st, b, a1, b1, c1, d1;
                st = (p == 0) ? 4 : 1;
                b  = (p == 0) ? g : 4*g;
                a1 = s16(m[b] + m[b+2*st]);
                b1 = s16(m[b] - m[b+2*st]);
                c1 = s16(sS(m[b+st]) - sC(m[b+3*st]));
                d1 = s16(sC(m[b+st]) + sS(m[b+3*st]));
                t[b]      = s16(a1 + d1);
                t[b+st]   = s16(b1 + c1);
                t[b+2*st] = s16(b1 - c1);
                t[b+3*st] = s16(a1 - d1);
            end
            m = t;
        end
        for (int k = 0; k < 16; k++) begin
            int v;
            v = ((m[k] + 4) >>> 3) + int'(pr[k*PW +: PW]);
            if (v < 0) v = 0;
            if (v > 255) v = 255;
            res[k*PW +: PW] = v[7:0];
        end
        return res;
    endfunction

    int               m_stage = 0;
    logic             e_done = 1'b0;
    logic [16*PW-1:0] e_pix = '0, e_pend = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_stage = 0; e_done = 1'b0; e_pix = '0;
        end else if (m_stage == 1) begin
            m_stage = 0; e_done = 1'b1; e_pix = e_pend;
        end else begin
            e_done = 1'b0;
            if (start_i) begin
                m_stage = 1;
                e_pend  = ref_tile(coef_i, pred_i);
            end
        end
    end

    task automatic chk(string req, logic [16*PW-1:0] act, logic [16*PW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        // R2/R3 handshake, R10 hold, data under current tag
        chk((tag == "R3") ? "R3" : (rst ? "R1" : "R2"), {126'b0, ready_o, done_o},
            {126'b0, (m_stage == 0), e_done});
        chk(e_done ? tag : (rst ? "R1" : "R10"), pix_o, e_pix);
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog at cycle %0d: actual running expected finished", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic [16*CW-1:0] fill_c(int v);
        logic [16*CW-1:0] r;
        for (int k = 0; k < 16; k++) r[k*CW +: CW] = v[CW-1:0];
        return r;
    endfunction
    function automatic logic [16*PW-1:0] fill_p(int v);
        logic [16*PW-1:0] r;
        for (int k = 0; k < 16; k++) r[k*PW +: PW] = v[PW-1:0];
        return r;
    endfunction
    function automatic logic [16*CW-1:0] rnd_c();
        logic [16*CW-1:0] r;
        for (int k = 0; k < 16; k++) r[k*CW +: CW] = CW'($urandom % 8192);
        return r;
    endfunction

    task automatic tile(string req, logic [16*CW-1:0] c, logic [16*PW-1:0] p);
        @(posedge clk); #1;
        tag = req; coef_i = c; pred_i = p; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);  // R1 checked while in reset
        #1 rst = 1'b0;
        repeat (2) @(posedge clk);

        // R8: DC-only tiles exercise the rounding by eight
        tile("R8", {{15*CW{1'b0}}, CW'(100)}, fill_p(128));
        tile("R8", {{15*CW{1'b0}}, CW'(-13)}, fill_p(50));
        tile("R8", {{15*CW{1'b0}}, CW'(4095)}, fill_p(0));
        // R4/R6: single coefficient off the diagonal shows orientation
        begin
            logic [16*CW-1:0] c;
            c = '0; c[1*CW +: CW] = CW'(700);
            tile("R6", c, fill_p(100));
            c = '0; c[4*CW +: CW] = CW'(700);
            tile("R6", c, fill_p(100));
            c = '0; c[14*CW +: CW] = CW'(-2000); c[7*CW +: CW] = CW'(1500);
            tile("R4", c, {8'd1,8'd2,8'd3,8'd4,8'd5,8'd6,8'd7,8'd8,
                           8'd9,8'd10,8'd11,8'd12,8'd13,8'd14,8'd15,8'd16});
        end
        // R7: extremes force the second pass to saturate
        tile("R7", fill_c(4095), fill_p(128));
        tile("R7", fill_c(-4096), fill_p(128));
        // R9: clamp at both ends
        tile("R9", fill_c(4095), fill_p(255));
        tile("R9", fill_c(-4096), fill_p(0));
        // R5: random tiles
        for (int i = 0; i < 300; i++) begin
            logic [16*PW-1:0] p;
            for (int k = 0; k < 16; k++) p[k*PW +: PW] = PW'($urandom);
            tile("R5", rnd_c(), p);
        end
        // R3: start held high with changing data; busy-cycle starts dropped
        @(posedge clk); #1;
        tag = "R3"; start_i = 1'b1;
        for (int i = 0; i < 8; i++) begin
            coef_i = rnd_c(); pred_i = fill_p(i * 30);
            @(posedge clk); #1;
        end
        start_i = 1'b0;
        repeat (4) @(posedge clk);
        // R10: long idle with inputs moving
        tag = "R10";
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); #1; coef_i = rnd_c(); pred_i = fill_p(i);
        end
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule